// File: doc/BRIEF.md
# Self-Selecting Identifier Bus Arbiter

This block decides which of several bus agents gets the bus. No central priority encoder picks the winner. Each agent holds a fixed identifier, presented on `agent_id`. The agents that request at the start of a round drive their identifiers onto a shared set of wired-OR lines. Each agent then watches the combined pattern and pulls back its own drivers where it sees that it is outranked. Lines are walked from the most significant bit down. The pattern converges on the largest identifier among the contenders, and only the agent whose identifier matches the settled pattern raises its grant.

The model is synchronous. The wired-OR lines are the bitwise OR of every agent's registered drive. Each clock edge in contention lets every agent apply one withdrawal step against the current pattern. A controller state machine has three states: IDLE, CONTEND and OWNED. Its transitions are:
- START: IDLE to CONTEND, taken when any request is present. It latches which agents take part.
- SETTLE: CONTEND to OWNED, taken when the pattern is unchanged from the previous step, or when the step cap equal to the identifier width is reached.
- RELEASE: OWNED to IDLE, taken when the granted agent drops its request. It clears all drivers.

Top module: `wired_id_arbiter`

## Requirements
- R1: After reset, `grant` is all zero, `arb_lines` is zero and `arb_active` is low.
- R2: The clock edge that takes START raises `arb_active`. In the cycle that follows, `arb_lines` equals the bitwise OR of the identifiers of all agents requesting at that edge.
- R3: On each contention step, an agent finds the most significant bit where the line is 1 and its own identifier bit is 0. It stops driving that bit and every lower bit. With identifiers 0101 and 0110 contending, the lines read 0111 after START and 0110 one edge later.
- R4: Once settled, `arb_lines` equals the largest identifier among the round's participants. Exactly one `grant` bit is high: the bit of the agent owning that identifier.
- R5: `grant` becomes non-zero no later than ID_W+2 clock edges after the edge that takes START, counting that edge as the first.
- R6: While the granted agent keeps its request high, `grant` and `arb_lines` stay unchanged. On the first edge where that request is low, `grant`, `arb_lines` and `arb_active` all return to zero.
- R7: An agent that raises its request after START takes no part in the current round and cannot win it, even with a larger identifier. It competes in the next round.
- R8: With no request present, the block stays idle: `arb_lines` reads 0000, `arb_active` is low and no grant is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N_AGENTS | Per-agent bus request |
| agent_id | input | N_AGENTS*ID_W | Fixed identifier per agent, agent k in bits [k*ID_W +: ID_W], all distinct |
| grant | output | N_AGENTS | Per-agent grant, at most one high |
| arb_lines | output | ID_W | Current wired-OR arbitration pattern |
| arb_active | output | 1 | High from START until RELEASE |

## Verification
The hardest case to reach from the ports is a late joiner. It needs an agent with a larger identifier to raise its request after START has latched the participants but before SETTLE. The bench does this by raising agent 3 (identifier 1001) one cycle after the start edge, in a round between identifiers 0101 and 0011. It then checks that the round is still won by 0101 and that agent 3 wins the following round. A second delicate case is a winner that has to withdraw temporarily. The bench pits 1001 against 0110: the early pattern 1111 makes the larger agent drop its low bits for one step before it re-drives them.

// File: rtl/wia_pkg.sv
package wia_pkg;
    typedef enum logic [1:0] {
        ARB_IDLE    = 2'd0,
        ARB_CONTEND = 2'd1,
        ARB_OWNED   = 2'd2
    } arb_state_t;
endpackage

// File: rtl/wia_agent.sv
module wia_agent #(
    parameter int ID_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ID_W-1:0] my_id,
    input  logic            req,
    input  logic            start,
    input  logic            step_en,
    input  logic            clear,
    input  logic            owned,
    input  logic [ID_W-1:0] lines,
    output logic [ID_W-1:0] drive,
    output logic            won
);
    logic joined;

    // Zero every bit at and below the highest position where the line is
    // high but this agent's identifier is low.
    function automatic logic [ID_W-1:0] pull_back(input logic [ID_W-1:0] id,
                                                  input logic [ID_W-1:0] pat);
        logic [ID_W-1:0] res;
        logic            hit;
        res = id;
        hit = 1'b0;
        for (int b = ID_W - 1; b >= 0; b--) begin
            if (pat[b] && !id[b]) hit = 1'b1;
            if (hit) res[b] = 1'b0;
        end
        return res;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            joined <= 1'b0;
            drive  <= '0;
        end else if (clear) begin
            joined <= 1'b0;
            drive  <= '0;
        end else if (start) begin
            joined <= req;
            drive  <= req ? my_id : '0;
        end else if (step_en && joined) begin
            drive  <= pull_back(my_id, lines);
        end
    end

    assign won = owned && joined && (lines == my_id);

    p_drive_subset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (drive & ~my_id) == '0);
    p_outsider_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !joined |-> (drive == '0) && !won);
endmodule

// File: rtl/wia_wired_or.sv
module wia_wired_or #(
    parameter int N_AGENTS = 4,
    parameter int ID_W     = 4
) (
    input  logic [N_AGENTS*ID_W-1:0] drives,
    output logic [ID_W-1:0]          lines
);
    always_comb begin
        lines = '0;
        for (int k = 0; k < N_AGENTS; k++) begin
            lines = lines | drives[k*ID_W +: ID_W];
        end
    end
endmodule

// File: rtl/wia_ctrl.sv
module wia_ctrl
    import wia_pkg::*;
#(
    parameter int ID_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            any_req,
    input  logic            winner_req,
    input  logic [ID_W-1:0] lines,
    output logic            start,
    output logic            step_en,
    output logic            clear,
    output logic            owned,
    output logic            active
);
    localparam int MAX_STEPS = ID_W;
    localparam int STEP_W    = $clog2(MAX_STEPS + 1);

    arb_state_t      state, state_nx;
    logic [STEP_W-1:0] steps;
    logic [ID_W-1:0]   prev_lines;
    logic              settled;

    assign settled = (steps != '0) &&
                     ((lines == prev_lines) || (steps == STEP_W'(MAX_STEPS)));

    always_comb begin
        state_nx = state;
        unique case (state)
            ARB_IDLE:    if (any_req)     state_nx = ARB_CONTEND;
            ARB_CONTEND: if (settled)     state_nx = ARB_OWNED;
            ARB_OWNED:   if (!winner_req) state_nx = ARB_IDLE;
            default:                      state_nx = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ARB_IDLE;
            steps      <= '0;
            prev_lines <= '0;
        end else begin
            state <= state_nx;
            if (state == ARB_CONTEND && !settled) begin
                steps      <= steps + 1'b1;
                prev_lines <= lines;
            end else if (state != ARB_CONTEND) begin
                steps      <= '0;
                prev_lines <= '0;
            end
        end
    end

    always_comb begin
        start   = 1'b0;
        step_en = 1'b0;
        clear   = 1'b0;
        owned   = 1'b0;
        active  = 1'b0;
        unique case (state)
            ARB_IDLE:    start = any_req;
            ARB_CONTEND: begin
                step_en = !settled;
                active  = 1'b1;
            end
            ARB_OWNED: begin
                owned  = 1'b1;
                active = 1'b1;
                clear  = !winner_req;
            end
            default: ;
        endcase
    end

    p_step_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        steps <= STEP_W'(MAX_STEPS));
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_IDLE) |-> (lines == '0));
    p_hold_lines_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_OWNED && $past(state == ARB_OWNED)) |-> $stable(lines));
endmodule

// File: rtl/wired_id_arbiter.sv
module wired_id_arbiter #(
    parameter int N_AGENTS = 4,
    parameter int ID_W     = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_AGENTS-1:0]      req,
    input  logic [N_AGENTS*ID_W-1:0] agent_id,
    output logic [N_AGENTS-1:0]      grant,
    output logic [ID_W-1:0]          arb_lines,
    output logic                     arb_active
);
    logic [N_AGENTS*ID_W-1:0] drives;
    logic start, step_en, clear, owned;
    logic winner_req;

    assign winner_req = |(req & grant);

    wia_ctrl #(.ID_W(ID_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_req    (|req),
        .winner_req (winner_req),
        .lines      (arb_lines),
        .start      (start),
        .step_en    (step_en),
        .clear      (clear),
        .owned      (owned),
        .active     (arb_active)
    );

    wia_wired_or #(.N_AGENTS(N_AGENTS), .ID_W(ID_W)) u_lines (
        .drives (drives),
        .lines  (arb_lines)
    );

    for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
        wia_agent #(.ID_W(ID_W)) u_agent (
            .clk     (clk),
            .rst_n   (rst_n),
            .my_id   (agent_id[g*ID_W +: ID_W]),
            .req     (req[g]),
            .start   (start),
            .step_en (step_en),
            .clear   (clear),
            .owned   (owned),
            .lines   (arb_lines),
            .drive   (drives[g*ID_W +: ID_W]),
            .won     (grant[g])
        );
    end

    p_single_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    p_grant_needs_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> arb_active);
endmodule

// File: tb/wired_id_arbiter_bench.sv
module wired_id_arbiter_bench;
    localparam int N  = 4;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic [N*IW-1:0] agent_id;
    logic [N-1:0]  grant;
    logic [IW-1:0] arb_lines;
    logic          arb_active;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int exp_q[$];
    logic [N-1:0] prev_grant = '0;

    // identifiers: agent0=5, agent1=6, agent2=3, agent3=9
    assign agent_id = {4'd9, 4'd3, 4'd6, 4'd5};

    always #5 clk = ~clk;

    wired_id_arbiter #(.N_AGENTS(N), .ID_W(IW)) u_wired_id_arbiter (
        .clk(clk), .rst_n(rst_n), .req(req), .agent_id(agent_id),
        .grant(grant), .arb_lines(arb_lines), .arb_active(arb_active)
    );

    function automatic logic [IW-1:0] id_of(input int k);
        return agent_id[k*IW +: IW];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // monitor: pops expected winner when a grant appears
    always @(negedge clk) begin
        if (rst_n && grant != '0 && prev_grant == '0) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected grant", int'(grant), 0);
            end else begin
                int w;
                w = exp_q.pop_front();
                chk(grant == (N'(1) << w), "R4 winner", int'(grant), 1 << w);
                chk(arb_lines == id_of(w), "R4 settled lines", int'(arb_lines), int'(id_of(w)));
            end
        end
        prev_grant = grant;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            chk(1'b0, "watchdog", cycles, 20000);
            summary();
        end
    end

    task automatic round(input logic [N-1:0] mask, input logic [N-1:0] late,
                         input bit do_r3, input logic [IW-1:0] exp_r3);
        logic [IW-1:0] exp_or;
        int best;
        int lat;
        logic [N-1:0] g_hold;
        exp_or = '0;
        best = -1;
        for (int k = 0; k < N; k++) begin
            if (mask[k]) begin
                exp_or = exp_or | id_of(k);
                if (best < 0 || id_of(k) > id_of(best)) best = k;
            end
        end
        exp_q.push_back(best);
        @(negedge clk);
        req = mask;
        @(negedge clk); // one edge after START
        chk(arb_active == 1'b1, "R2 active", int'(arb_active), 1);
        chk(arb_lines == exp_or, "R2 initial OR", int'(arb_lines), int'(exp_or));
        req = mask | late;
        lat = 1;
        if (grant == '0) begin
            @(negedge clk);
            lat++;
            if (do_r3) chk(arb_lines == exp_r3, "R3 withdrawal", int'(arb_lines), int'(exp_r3));
            while (grant == '0 && lat < 10) begin
                @(negedge clk);
                lat++;
            end
        end
        chk(lat <= IW + 2, "R5 latency", lat, IW + 2);
        chk((grant & late) == '0, "R7 late joiner excluded", int'(grant), 0);
        g_hold = grant;
        for (int h = 0; h < 2; h++) begin
            @(negedge clk);
            chk(grant == g_hold && arb_lines == id_of(best), "R6 hold",
                int'(arb_lines), int'(id_of(best)));
        end
        req = '0;
        @(negedge clk);
        chk(grant == '0 && arb_lines == '0 && !arb_active, "R6 release",
            int'({arb_active, grant, arb_lines}), 0);
    endtask

    initial begin
        #1;
        chk(grant == '0 && arb_lines == '0 && !arb_active, "R1 reset",
            int'({arb_active, grant, arb_lines}), 0);
        #20 rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(grant == '0 && arb_lines == '0 && !arb_active, "R8 idle",
                int'({arb_active, grant, arb_lines}), 0);
        end
        round(4'b0011, 4'b0000, 1'b1, 4'b0110); // 5 vs 6
        round(4'b1010, 4'b0000, 1'b1, 4'b1000); // 9 vs 6: 9 withdraws once
        round(4'b0101, 4'b1000, 1'b0, 4'b0000); // 5 vs 3, 9 joins late
        round(4'b1000, 4'b0000, 1'b0, 4'b0000); // R7: late joiner's next round
        round(4'b1111, 4'b0000, 1'b0, 4'b0000);
        round(4'b0100, 4'b0000, 1'b0, 4'b0000);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(grant == '0 && arb_lines == '0 && !arb_active, "R8 idle end",
                int'({arb_active, grant, arb_lines}), 0);
        end
        chk(exp_q.size() == 0, "R4 all rounds granted", exp_q.size(), 0);
        summary();
    end
endmodule